// File: doc/BRIEF.md
# Strided Vector Slice Address Generator

This block turns one strided vector memory command into quadword addresses grouped for a cache with sixteen banks. A command gives a base byte address, a signed stride counted in quadwords, and a vector length from 0 to 128. The block covers the 128 element positions in eight slices. Each slice holds one element for each of the sixteen lanes. The elements are not taken in index order. A fixed ordering function of the stride's power-of-two exponent `s`, its odd part and the slice number picks, for every lane, which of the eight elements in that lane is issued in each slice. With this choice the sixteen addresses of a slice fall in sixteen different banks.

The stride is read as an odd number times `2^s`. With 64-byte lines, a collision-free ordering exists only up to `s = 3`. A stride whose low four bits are all zero (this includes a zero stride) therefore raises a one-cycle self-conflict flag. No slices are issued for it, and the command goes to a separate conflict-resolution path. A run always lasts eight slice cycles, however short the vector. Positions at or above the vector length still go out, with their valid bit cleared.

Top module: `stride_agen`

## Requirements
- R1: After reset, `slice_vld_o` and `self_conf_o` are low.
- R2: A `start_i` pulse seen while idle with `stride_i[3:0]` not zero gives exactly eight consecutive cycles of `slice_vld_o`. The first of these is the cycle after the start edge. `slice_idx_o` counts 0 to 7 across them, and `slice_vld_o` is low in the following cycle.
- R3: Output position p (0..15) is lane p. The element index it carries satisfies index mod 16 = p.
- R4: Across the eight slices of a run, each element index 0..127 appears exactly once.
- R5: The address at a position is `base_i + index * stride_i * 8` modulo 2^AW, with `stride_i` taken as two's complement.
- R6: `lane_vld_o[p]` is high exactly when that position's index is below `vlen_i`. All eight slices are issued even for `vlen_i` of 0 or 1.
- R7: The bank of an address is its bits [9:6]. When the base is 64-byte aligned and the stride is accepted, the sixteen positions of every slice name sixteen different banks.
- R8: If `stride_i[3:0]` is zero at an accepted start, `self_conf_o` is high for the next cycle only, and no slice is issued.
- R9: A `start_i` pulse during a run is ignored. The run keeps its own base, stride and length, and no second run or flag follows.
- R10: The ordering is not sequential. Slice 0 of a unit-stride run does not hold indices 0..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command pulse, taken only when idle |
| base_i | input | AW | Base byte address |
| stride_i | input | SW | Signed stride in quadwords |
| vlen_i | input | 8 | Vector length, 0..128 |
| slice_vld_o | output | 1 | A slice is on the outputs |
| slice_idx_o | output | 3 | Slice number within the run |
| elem_o | output | 16*7 | Element index per lane position |
| addr_o | output | 16*AW | Byte address per lane position |
| lane_vld_o | output | 16 | Element index below vector length |
| self_conf_o | output | 1 | Stride exponent above 3, command refused |

## Verification
Four properties are checked on every cycle by assertions. The slice counter advances without gaps and ends after slice 7, and the latched command stays unchanged through a run. No element index repeats within a run and all 128 are covered by its last slice. Aligned runs never put two positions in one bank. The scenarios alone can show the exact address arithmetic for positive, negative, odd and even strides and the valid masks for short lengths. They also show that a start during a run leaves no trace, and that the flag replaces the slices with the right timing.

// File: rtl/stride_agen_pkg.sv
package stride_agen_pkg;
  localparam int LANES  = 16;
  localparam int SLICES = 8;
  localparam int ELEMS  = LANES * SLICES;
  localparam int LW     = $clog2(LANES);
  localparam int KW     = $clog2(SLICES);
  localparam int EW     = $clog2(ELEMS);
  localparam int LINE_B = 64;
  localparam int QPL    = LINE_B / 8;
  localparam int S_LIM  = $clog2(QPL);
  localparam int SLW    = $clog2(S_LIM + 1);
  localparam int BANK_LO = $clog2(LINE_B);

  // Row j (0..7) taken by a lane in slice k. Bank of lane l splits into a
  // part fixed by l*u and a part steered by j*u; w = S_LIM - s bits steerable.
  function automatic logic [KW-1:0] pick_row(input logic [SLW-1:0] s,
                                             input logic [EW-1:0]  u,
                                             input logic [LW-1:0]  lane,
                                             input logic [KW-1:0]  k);
    logic [EW-1:0] lu;
    logic [KW-1:0] w, m, t, lh, jl;
    lu = EW'({{(EW-LW){1'b0}}, lane} * u);
    w  = KW'(S_LIM) - KW'(s);
    m  = ~({KW{1'b1}} << w);
    lh = KW'(lu >> (EW - KW));
    t  = (k + KW'(lu)) & m;
    jl = ((t - lh) * KW'(u)) & m;
    return jl | (k & ~m);
  endfunction
endpackage

// File: rtl/stride_agen_ctrl.sv
module stride_agen_ctrl
  import stride_agen_pkg::*;
#(
  parameter int AW = 40,
  parameter int SW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  base_i,
  input  logic [SW-1:0]  stride_i,
  input  logic [EW:0]    vlen_i,
  output logic           busy_o,
  output logic [KW-1:0]  k_o,
  output logic [SLW-1:0] s_o,
  output logic [EW-1:0]  u_o,
  output logic [AW-1:0]  base_o,
  output logic [SW-1:0]  stride_o,
  output logic [EW:0]    vl_o,
  output logic           flag_o
);
  logic           go, hi_pow;
  logic [SLW-1:0] s_d;
  logic [EW-1:0]  u_d;

  always_comb begin
    s_d = SLW'(S_LIM);
    for (int b = S_LIM - 1; b >= 0; b--)
      if (stride_i[b]) s_d = SLW'(b);
  end

  assign u_d    = EW'(stride_i >> s_d);
  assign hi_pow = ~|stride_i[S_LIM:0];
  assign go     = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      k_o      <= '0;
      s_o      <= '0;
      u_o      <= '0;
      base_o   <= '0;
      stride_o <= '0;
      vl_o     <= '0;
      flag_o   <= 1'b0;
    end else begin
      flag_o <= go && hi_pow;
      if (go) begin
        busy_o   <= !hi_pow;
        k_o      <= '0;
        s_o      <= s_d;
        u_o      <= u_d;
        base_o   <= base_i;
        stride_o <= stride_i;
        vl_o     <= vlen_i;
      end else if (busy_o) begin
        k_o <= k_o + 1'b1;
        if (k_o == KW'(SLICES - 1)) busy_o <= 1'b0;
      end
    end
  end

  AST_RUN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && k_o != KW'(SLICES - 1) |=> busy_o && k_o == $past(k_o) + 1'b1); // R2
  AST_RUN_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && k_o == KW'(SLICES - 1) |=> !busy_o); // R2
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && k_o != KW'(SLICES - 1) |=> $stable(base_o) && $stable(stride_o) && $stable(vl_o)); // R9
  AST_FLAG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> !busy_o); // R8
endmodule

// File: rtl/stride_agen_order.sv
module stride_agen_order
  import stride_agen_pkg::*;
(
  input  logic [SLW-1:0]      s_i,
  input  logic [EW-1:0]       u_i,
  input  logic [KW-1:0]       k_i,
  output logic [LANES*EW-1:0] elem_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign elem_o[l*EW +: EW] = {pick_row(s_i, u_i, LW'(l), k_i), LW'(l)};
  end
endmodule

// File: rtl/stride_agen_lane.sv
module stride_agen_lane
  import stride_agen_pkg::*;
#(
  parameter int AW = 40,
  parameter int SW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] stride_i,
  input  logic [EW-1:0] elem_i,
  input  logic [EW:0]   vl_i,
  output logic [AW-1:0] addr_o,
  output logic          vld_o
);
  localparam int PW = SW + EW + 1;
  logic signed [PW-1:0] prod;
  logic [AW-1:0]        offs;

  assign prod   = $signed({1'b0, elem_i}) * $signed(stride_i);
  assign offs   = {{(AW-PW-3){prod[PW-1]}}, prod, 3'b000};
  assign addr_o = base_i + offs;
  assign vld_o  = {1'b0, elem_i} < vl_i;
endmodule

// File: rtl/stride_agen.sv
module stride_agen
  import stride_agen_pkg::*;
#(
  parameter int AW = 40,
  parameter int SW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [AW-1:0]       base_i,
  input  logic [SW-1:0]       stride_i,
  input  logic [EW:0]         vlen_i,
  output logic                slice_vld_o,
  output logic [KW-1:0]       slice_idx_o,
  output logic [LANES*EW-1:0] elem_o,
  output logic [LANES*AW-1:0] addr_o,
  output logic [LANES-1:0]    lane_vld_o,
  output logic                self_conf_o
);
  logic           busy;
  logic [KW-1:0]  k;
  logic [SLW-1:0] s;
  logic [EW-1:0]  u;
  logic [AW-1:0]  base_q;
  logic [SW-1:0]  stride_q;
  logic [EW:0]    vl_q;

  stride_agen_ctrl #(.AW(AW), .SW(SW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .base_i, .stride_i, .vlen_i,
    .busy_o(busy), .k_o(k), .s_o(s), .u_o(u), .base_o(base_q),
    .stride_o(stride_q), .vl_o(vl_q), .flag_o(self_conf_o)
  );

  stride_agen_order u_order (.s_i(s), .u_i(u), .k_i(k), .elem_o(elem_o));

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    stride_agen_lane #(.AW(AW), .SW(SW)) u_lane (
      .base_i(base_q), .stride_i(stride_q), .elem_i(elem_o[p*EW +: EW]),
      .vl_i(vl_q), .addr_o(addr_o[p*AW +: AW]), .vld_o(lane_vld_o[p])
    );
  end

  assign slice_vld_o = busy;
  assign slice_idx_o = k;

  // checker state: banks hit in this slice, elements issued so far in the run
  logic [LANES-1:0] bank_hit;
  logic [ELEMS-1:0] cur_set, seen_q;

  always_comb begin
    bank_hit = '0;
    cur_set  = '0;
    for (int p = 0; p < LANES; p++) begin
      bank_hit |= LANES'(1) << addr_o[p*AW + BANK_LO +: LW];
      cur_set  |= ELEMS'(1) << elem_o[p*EW +: EW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (busy && k != KW'(SLICES - 1)) seen_q <= seen_q | cur_set;
    else seen_q <= '0;
  end

  AST_BANKS_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && base_q[BANK_LO-1:0] == '0 |-> &bank_hit); // R7
  AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (seen_q & cur_set) == '0); // R4
  AST_FULL_COVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && k == KW'(SLICES - 1) |-> &(seen_q | cur_set)); // R4
  AST_FLAG_NO_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_conf_o |-> !slice_vld_o); // R8
endmodule

// File: tb/stride_agen_test.sv
`timescale 1ns/1ps
module stride_agen_test;
  localparam int AW = 40;
  localparam int SW = 16;

  typedef struct {
    logic [AW-1:0] base;
    logic [SW-1:0] stride;
    logic [7:0]    vl;
    bit            flag;
  } cmd_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [AW-1:0]  base = '0;
  logic [SW-1:0]  stride = '0;
  logic [7:0]     vlen = '0;
  logic           slice_vld, self_conf;
  logic [2:0]     slice_idx;
  logic [16*7-1:0]  elem;
  logic [16*AW-1:0] addr;
  logic [15:0]    lane_vld;

  int   total = 0, bad = 0;
  bit   finished = 0;
  cmd_t q[$];

  stride_agen #(.AW(AW), .SW(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .stride_i(stride), .vlen_i(vlen), .slice_vld_o(slice_vld),
    .slice_idx_o(slice_idx), .elem_o(elem), .addr_o(addr),
    .lane_vld_o(lane_vld), .self_conf_o(self_conf)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: issue a command and push what the monitor must see
  task automatic run_cmd(input logic [AW-1:0] b, input logic [SW-1:0] st, input logic [7:0] vl);
    cmd_t c;
    c.base = b; c.stride = st; c.vl = vl; c.flag = (st[3:0] == 4'd0);
    @(negedge clk);
    base = b; stride = st; vlen = vl; start = 1'b1;
    q.push_back(c);
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // monitor: pop expected command when the design produces output
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (slice_vld || self_conf)) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 output without accepted command", {slice_vld, self_conf}, 0);
        end else begin
          cmd_t c;
          int   seen [128];
          c = q.pop_front();
          foreach (seen[e]) seen[e] = 0;
          if (c.flag) begin
            chk(self_conf && !slice_vld, "R8 flag instead of slices", {self_conf, slice_vld}, 2);
            @(negedge clk);
            chk(!slice_vld && !self_conf, "R8 one-cycle flag, no slices", {self_conf, slice_vld}, 0);
          end else begin
            for (int k = 0; k < 8; k++) begin
              logic [15:0] hit;
              int dup;
              hit = '0; dup = 0;
              chk(slice_vld && !self_conf, "R2 slice present", {slice_vld, self_conf}, 2);
              chk(slice_idx == 3'(k), "R2 slice number", slice_idx, k);
              for (int p = 0; p < 16; p++) begin
                logic [6:0]    e;
                logic [AW-1:0] a, ea;
                longint        off;
                e = elem[p*7 +: 7];
                a = addr[p*AW +: AW];
                off = longint'(e) * longint'($signed(c.stride)) * 8;
                ea = c.base + AW'(off);
                seen[e]++;
                chk(e[3:0] == 4'(p), "R3 lane of element", e, p);
                chk(a == ea, "R5 address", a, ea);
                chk(lane_vld[p] == ({1'b0, e} < c.vl), "R6 valid bit", lane_vld[p], ({1'b0, e} < c.vl));
                if (lane_vld[p]) begin
                  if (hit[a[9:6]]) dup++;
                  hit[a[9:6]] = 1'b1;
                end
              end
              if (c.base[5:0] == 6'd0)
                chk(dup == 0, "R7 distinct banks in slice", dup, 0);
              if (k == 0 && c.stride == 16'd1) begin
                int seq;
                seq = 1;
                for (int p = 0; p < 16; p++) if (elem[p*7 +: 7] != 7'(p)) seq = 0;
                chk(seq == 0, "R10 order not sequential", seq, 0);
              end
              if (k < 7) @(negedge clk);
            end
            begin
              int badidx;
              badidx = 0;
              foreach (seen[e]) if (seen[e] != 1) badidx++;
              chk(badidx == 0, "R4 each index once", badidx, 0);
            end
            @(negedge clk);
            chk(!slice_vld, "R2 run ends after eight slices", slice_vld, 0);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!slice_vld && !self_conf, "R1 reset state", {slice_vld, self_conf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!slice_vld && !self_conf, "R1 idle after reset", {slice_vld, self_conf}, 0);

    run_cmd(40'h00_0000_1000, 16'd1,      8'd128); // R10 unit stride
    run_cmd(40'h00_0002_0040, 16'd3,      8'd100);
    run_cmd(40'h00_0000_4000, 16'd6,      8'd128);
    run_cmd(40'h00_0123_4540, 16'd12,     8'd37);
    run_cmd(40'h00_0000_8000, 16'd8,      8'd128);
    run_cmd(40'h00_0008_0000, 16'hFFFB,   8'd128); // negative stride
    run_cmd(40'h00_0000_0000, 16'd40,     8'd1);   // R6 short vector
    run_cmd(40'h00_0000_0c00, 16'd7,      8'd0);   // R6 zero length
    run_cmd(40'h00_0000_1008, 16'd3,      8'd128); // misaligned base
    run_cmd(40'hFF_FFFF_FF00, 16'd125,    8'd64);  // address wrap
    run_cmd(40'h00_0000_2000, 16'd16,     8'd128); // R8 s=4
    run_cmd(40'h00_0000_2000, 16'd0,      8'd128); // R8 zero stride
    run_cmd(40'h00_0000_2000, 16'd96,     8'd128); // R8 s=5

    // R9: start during a run must be ignored
    begin
      cmd_t c;
      c.base = 40'h00_0000_6000; c.stride = 16'd5; c.vl = 8'd90; c.flag = 0;
      @(negedge clk);
      base = c.base; stride = c.stride; vlen = c.vl; start = 1'b1;
      q.push_back(c);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      base = 40'h00_0000_9000; stride = 16'd16; vlen = 8'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (14) @(negedge clk);
      chk(q.size() == 0, "R9 run completed with its own command", q.size(), 0);
    end

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule